// File: doc/BRIEF.md
# UART Receiver Resynchronisation (Hunt) Controller

This block decides when a UART receiver may hand characters onward. It sits behind a deserializer that reports decoded events: a character strobe, the address bit carried by that character, an idle-line detection and a break detection. While the controller is hunting, every character is held back. It leaves the hunting state only on a resynchronisation event, and a mode input selects which event counts. In idle mode, one full idle character on the line re-enables reception. In address mode, the next character whose address bit is set re-enables reception, and that character is passed on as the first one accepted.

Software, or a higher-level controller, can force the block back into hunting with a one-cycle command strobe. If a message is partly received when the command arrives, the block raises a one-cycle abort pulse. Breaks seen while hunting are counted in a saturating counter, which has a clear strobe, and they set a sticky interrupt flag, which is cleared by writing one.

The control path is a three-state machine. HUNT means reception is disabled. READY means reception is enabled and no message is open. MSG means at least one character has been accepted since reception was enabled or since the last idle. The transitions are:

- HUNT to READY on an idle detection in idle mode.
- HUNT to MSG on a character with its address bit set in address mode.
- READY to MSG on any character.
- MSG to READY on an idle detection.
- Any state to HUNT on the command strobe. The command has priority over every other transition.

Top module: `rx_hunt_ctrl`

## Requirements
- R1: After reset, rx_en_o, abort_o and brk_irq_o are 0, brk_cnt_o is 0, and the state is HUNT.
- R2: While hunting, rx_en_o is 0, and char_pass_o is 0 for every character except the address-mode resync character of R4.
- R3: In idle mode (mode_addr_i = 0), idle_det_i while hunting sets rx_en_o on the next cycle, and later characters pass in the cycle they are presented. A character with its address bit set does not end the hunt in idle mode.
- R4: In address mode (mode_addr_i = 1), a character with ch_addr_i = 1 while hunting passes in the same cycle and sets rx_en_o on the next cycle. idle_det_i and characters without the address bit do not end the hunt.
- R5: hunt_cmd_i forces HUNT from any state, so rx_en_o is 0 on the next cycle. A character presented in the same cycle as the command does not pass.
- R6: hunt_cmd_i in state MSG raises abort_o for exactly one cycle, on the cycle after the command. A command in HUNT or READY raises no abort.
- R7: brk_det_i while hunting increments brk_cnt_o and sets brk_irq_o on the next cycle. A break while reception is enabled changes neither.
- R8: brk_cnt_o (16 bits by default) saturates at 65535 and holds there on further breaks.
- R9: cnt_clr_i zeroes brk_cnt_o on the next cycle, and it wins over an increment in the same cycle.
- R10: brk_irq_o stays set until irq_clr_i clears it on the next cycle. A break in the same cycle as the clear keeps it set.
- R11: idle_det_i in MSG closes the message (state READY), so a later command raises no abort.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ch_valid_i | input | 1 | A decoded character is present this cycle |
| ch_addr_i | input | 1 | Address bit of the present character |
| idle_det_i | input | 1 | One idle character time detected |
| brk_det_i | input | 1 | Break sequence detected |
| hunt_cmd_i | input | 1 | Force-hunt command strobe |
| mode_addr_i | input | 1 | 1: resync on address bit, 0: resync on idle |
| cnt_clr_i | input | 1 | Clear strobe for the break counter |
| irq_clr_i | input | 1 | Write-one-to-clear for the break flag |
| rx_en_o | output | 1 | Reception enabled (not hunting) |
| char_pass_o | output | 1 | Present character is accepted |
| abort_o | output | 1 | One-cycle message-abort pulse |
| brk_cnt_o | output | 16 | Saturating break counter |
| brk_irq_o | output | 1 | Sticky break interrupt flag |

## Verification
The hunt exit is driven in both modes with all three candidate events: idle detection, a plain character and an address-bit character. This shows that only the event chosen by the mode ends the hunt, and that only in address mode does the resync character itself pass. The force-hunt command is issued in READY, in MSG and just after an idle has closed a message, which separates a real abort from a command with nothing to abort. Breaks are applied while hunting and while enabled, together with counter clears, flag clears and a long run that reaches saturation, so that each priority and limit is exercised at its edge.

// File: rtl/rx_hunt_pkg.sv
package rx_hunt_pkg;

    typedef enum logic [1:0] {
        ST_HUNT  = 2'd0,
        ST_READY = 2'd1,
        ST_MSG   = 2'd2
    } hunt_state_e;

endpackage

// File: rtl/rx_hunt_fsm.sv
module rx_hunt_fsm
    import rx_hunt_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        ch_valid_i,
    input  logic        ch_addr_i,
    input  logic        idle_det_i,
    input  logic        hunt_cmd_i,
    input  logic        mode_addr_i,
    output logic        hunting_o,
    output logic        char_pass_o,
    output logic        abort_o
);

    hunt_state_e state_q, state_d;
    logic        resync_addr;
    logic        resync_idle;

    assign resync_addr = mode_addr_i && ch_valid_i && ch_addr_i;
    assign resync_idle = !mode_addr_i && idle_det_i;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_HUNT;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        if (hunt_cmd_i) begin
            state_d = ST_HUNT;
        end else begin
            unique case (state_q)
                ST_HUNT: begin
                    if (resync_addr)      state_d = ST_MSG;
                    else if (resync_idle) state_d = ST_READY;
                end
                ST_READY: begin
                    if (ch_valid_i)       state_d = ST_MSG;
                end
                ST_MSG: begin
                    if (idle_det_i)       state_d = ST_READY;
                end
                default:                  state_d = ST_HUNT;
            endcase
        end
    end

    // outputs
    always_comb begin
        hunting_o   = (state_q == ST_HUNT);
        char_pass_o = 1'b0;
        if (ch_valid_i && !hunt_cmd_i) begin
            unique case (state_q)
                ST_HUNT:  char_pass_o = resync_addr;
                ST_READY: char_pass_o = 1'b1;
                ST_MSG:   char_pass_o = 1'b1;
                default:  char_pass_o = 1'b0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) abort_o <= 1'b0;
        else        abort_o <= hunt_cmd_i && (state_q == ST_MSG);
    end

    // R5: a command always lands in HUNT
    a_r5_cmd_to_hunt: assert property (@(posedge clk) disable iff (!rst_n)
        hunt_cmd_i |=> (state_q == ST_HUNT));
    // R6: abort is a single-cycle pulse caused by a command
    a_r6_abort_single: assert property (@(posedge clk) disable iff (!rst_n)
        abort_o |=> !abort_o);
    a_r6_abort_cause: assert property (@(posedge clk) disable iff (!rst_n)
        abort_o |-> $past(hunt_cmd_i));
    // R4: address-bit character ends the hunt in address mode
    a_r4_addr_resync: assert property (@(posedge clk) disable iff (!rst_n)
        (hunting_o && mode_addr_i && ch_valid_i && ch_addr_i && !hunt_cmd_i)
            |=> (state_q == ST_MSG));
    // R3: idle ends the hunt in idle mode
    a_r3_idle_resync: assert property (@(posedge clk) disable iff (!rst_n)
        (hunting_o && !mode_addr_i && idle_det_i && !hunt_cmd_i)
            |=> (state_q == ST_READY));
    // R11: idle closes an open message
    a_r11_idle_close: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_MSG && idle_det_i && !hunt_cmd_i) |=> (state_q == ST_READY));

endmodule

// File: rtl/rx_hunt_brk_cnt.sv
module rx_hunt_brk_cnt #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc_i,
    input  logic             clr_i,
    output logic [CNT_W-1:0] cnt_o
);

    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                          cnt_o <= '0;
        else if (clr_i)                      cnt_o <= '0;
        else if (inc_i && cnt_o != CNT_MAX)  cnt_o <= cnt_o + 1'b1;
    end

    // R8: saturation holds
    a_r8_sat_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_o == CNT_MAX && !clr_i) |=> (cnt_o == CNT_MAX));
    // R9: clear wins
    a_r9_clear: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (cnt_o == '0));
    // R7: one step per break below the limit
    a_r7_inc: assert property (@(posedge clk) disable iff (!rst_n)
        (inc_i && !clr_i && cnt_o != CNT_MAX) |=> (cnt_o == $past(cnt_o) + 1'b1));

endmodule

// File: rtl/rx_hunt_flag.sv
module rx_hunt_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic w1c_i,
    output logic flag_o
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      flag_o <= 1'b0;
        else if (set_i)  flag_o <= 1'b1;
        else if (w1c_i)  flag_o <= 1'b0;
    end

    // R10: sticky until cleared, set wins
    a_r10_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_o && !w1c_i) |=> flag_o);
    a_r10_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        set_i |=> flag_o);

endmodule

// File: rtl/rx_hunt_ctrl.sv
module rx_hunt_ctrl #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ch_valid_i,
    input  logic             ch_addr_i,
    input  logic             idle_det_i,
    input  logic             brk_det_i,
    input  logic             hunt_cmd_i,
    input  logic             mode_addr_i,
    input  logic             cnt_clr_i,
    input  logic             irq_clr_i,
    output logic             rx_en_o,
    output logic             char_pass_o,
    output logic             abort_o,
    output logic [CNT_W-1:0] brk_cnt_o,
    output logic             brk_irq_o
);

    logic hunting;
    logic brk_hit;

    rx_hunt_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .ch_valid_i  (ch_valid_i),
        .ch_addr_i   (ch_addr_i),
        .idle_det_i  (idle_det_i),
        .hunt_cmd_i  (hunt_cmd_i),
        .mode_addr_i (mode_addr_i),
        .hunting_o   (hunting),
        .char_pass_o (char_pass_o),
        .abort_o     (abort_o)
    );

    assign rx_en_o = !hunting;
    assign brk_hit = brk_det_i && hunting;

    rx_hunt_brk_cnt #(.CNT_W(CNT_W)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .inc_i (brk_hit),
        .clr_i (cnt_clr_i),
        .cnt_o (brk_cnt_o)
    );

    rx_hunt_flag u_irq (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (brk_hit),
        .w1c_i  (irq_clr_i),
        .flag_o (brk_irq_o)
    );

    // R2: nothing passes while hunting except an address-mode resync character
    a_r2_no_pass_hunt: assert property (@(posedge clk) disable iff (!rst_n)
        (!rx_en_o && !(mode_addr_i && ch_addr_i)) |-> !char_pass_o);
    // R7: a break seen while hunting raises the flag
    a_r7_irq_on_brk: assert property (@(posedge clk) disable iff (!rst_n)
        (brk_det_i && !rx_en_o) |=> brk_irq_o);
    // R7: counter untouched by breaks while enabled
    a_r7_no_count_enabled: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_en_o && !cnt_clr_i) |=> $stable(brk_cnt_o));

endmodule

// File: tb/rx_hunt_ctrl_tb.sv
module rx_hunt_ctrl_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ch_valid = 0, ch_addr = 0, idle_det = 0, brk_det = 0;
    logic        hunt_cmd = 0, mode_addr = 0, cnt_clr = 0, irq_clr = 0;
    logic        rx_en, char_pass, abort_p, brk_irq;
    logic [15:0] brk_cnt;

    int cyc = 0;
    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    typedef struct {
        int    due;
        int    sig;
        int    val;
        string req;
    } exp_t;
    exp_t sb[$];

    localparam int SIG_EN = 0, SIG_PASS = 1, SIG_ABORT = 2, SIG_CNT = 3, SIG_IRQ = 4;

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    rx_hunt_ctrl u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .ch_valid_i  (ch_valid),
        .ch_addr_i   (ch_addr),
        .idle_det_i  (idle_det),
        .brk_det_i   (brk_det),
        .hunt_cmd_i  (hunt_cmd),
        .mode_addr_i (mode_addr),
        .cnt_clr_i   (cnt_clr),
        .irq_clr_i   (irq_clr),
        .rx_en_o     (rx_en),
        .char_pass_o (char_pass),
        .abort_o     (abort_p),
        .brk_cnt_o   (brk_cnt),
        .brk_irq_o   (brk_irq)
    );

    function automatic int sample(int sig);
        case (sig)
            SIG_EN:    return int'(rx_en);
            SIG_PASS:  return int'(char_pass);
            SIG_ABORT: return int'(abort_p);
            SIG_CNT:   return int'(brk_cnt);
            default:   return int'(brk_irq);
        endcase
    endfunction

    // driver: one cycle of stimulus, applied after the edge
    task automatic drive(bit v, bit a, bit idl, bit brk, bit cmd, bit cc, bit ic);
        @(posedge clk);
        #2;
        ch_valid = v; ch_addr = a; idle_det = idl; brk_det = brk;
        hunt_cmd = cmd; cnt_clr = cc; irq_clr = ic;
    endtask

    task automatic nop();
        drive(0, 0, 0, 0, 0, 0, 0);
    endtask

    // push an expectation: delay 0 = this cycle, 1 = after the next edge
    task automatic expect_sig(int sig, int val, int delay, string req);
        exp_t e;
        e.due = cyc + delay;
        e.sig = sig;
        e.val = val;
        e.req = req;
        sb.push_back(e);
    endtask

    // monitor: compare due items late in each cycle
    initial begin
        forever begin
            @(posedge clk);
            #6;
            for (int i = sb.size() - 1; i >= 0; i--) begin
                if (sb[i].due == cyc) begin
                    int got;
                    got = sample(sb[i].sig);
                    n_chk++;
                    if (got != sb[i].val) begin
                        n_fail++;
                        $display("FAIL %s signal %0d actual %0d expected %0d at cycle %0d",
                                 sb[i].req, sb[i].sig, got, sb[i].val, cyc);
                    end
                    sb.delete(i);
                end
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++;
            n_chk++;
            $display("FAIL watchdog actual hung expected finish");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;
        // R1: reset state
        expect_sig(SIG_EN, 0, 0, "R1");
        expect_sig(SIG_ABORT, 0, 0, "R1");
        expect_sig(SIG_CNT, 0, 0, "R1");
        expect_sig(SIG_IRQ, 0, 0, "R1");

        // idle mode hunt
        mode_addr = 0;
        drive(1, 1, 0, 0, 0, 0, 0);
        expect_sig(SIG_PASS, 0, 0, "R3");      // address char ignored in idle mode
        expect_sig(SIG_EN, 0, 1, "R3");
        drive(1, 0, 0, 0, 0, 0, 0);
        expect_sig(SIG_PASS, 0, 0, "R2");
        drive(0, 0, 1, 0, 0, 0, 0);
        expect_sig(SIG_EN, 1, 1, "R3");
        drive(1, 0, 0, 0, 0, 0, 0);
        expect_sig(SIG_PASS, 1, 0, "R3");
        // now MSG; close with idle, command in READY: no abort
        drive(0, 0, 1, 0, 0, 0, 0);
        drive(0, 0, 0, 0, 1, 0, 0);
        expect_sig(SIG_ABORT, 0, 1, "R11");
        expect_sig(SIG_EN, 0, 1, "R5");

        // abort in MSG
        drive(0, 0, 1, 0, 0, 0, 0);
        drive(1, 0, 0, 0, 0, 0, 0);
        drive(1, 0, 0, 0, 1, 0, 0);
        expect_sig(SIG_PASS, 0, 0, "R5");
        expect_sig(SIG_ABORT, 1, 1, "R6");
        expect_sig(SIG_EN, 0, 1, "R5");
        nop();
        expect_sig(SIG_ABORT, 0, 1, "R6");
        // command while hunting: no abort
        drive(0, 0, 0, 0, 1, 0, 0);
        expect_sig(SIG_ABORT, 0, 1, "R6");

        // address mode
        mode_addr = 1;
        drive(0, 0, 1, 0, 0, 0, 0);
        expect_sig(SIG_EN, 0, 1, "R4");
        drive(1, 0, 0, 0, 0, 0, 0);
        expect_sig(SIG_PASS, 0, 0, "R4");
        expect_sig(SIG_EN, 0, 1, "R4");
        drive(1, 1, 0, 0, 0, 0, 0);
        expect_sig(SIG_PASS, 1, 0, "R4");
        expect_sig(SIG_EN, 1, 1, "R4");
        drive(1, 0, 0, 0, 0, 0, 0);
        expect_sig(SIG_PASS, 1, 0, "R4");
        drive(0, 0, 0, 0, 1, 0, 0);
        expect_sig(SIG_ABORT, 1, 1, "R6");

        // breaks while hunting
        drive(0, 0, 0, 1, 0, 0, 0);
        expect_sig(SIG_CNT, 1, 1, "R7");
        expect_sig(SIG_IRQ, 1, 1, "R7");
        nop();
        expect_sig(SIG_IRQ, 1, 1, "R10");
        drive(0, 0, 0, 0, 0, 0, 1);
        expect_sig(SIG_IRQ, 0, 1, "R10");
        drive(0, 0, 0, 1, 0, 0, 1);
        expect_sig(SIG_IRQ, 1, 1, "R10");
        expect_sig(SIG_CNT, 2, 1, "R7");
        drive(0, 0, 0, 1, 0, 1, 1);
        expect_sig(SIG_CNT, 0, 1, "R9");
        drive(0, 0, 0, 0, 0, 0, 1);
        expect_sig(SIG_IRQ, 0, 1, "R10");

        // break while enabled: ignored
        mode_addr = 0;
        drive(0, 0, 1, 0, 0, 0, 0);
        drive(0, 0, 0, 1, 0, 0, 0);
        expect_sig(SIG_EN, 1, 0, "R7");
        expect_sig(SIG_CNT, 0, 1, "R7");
        expect_sig(SIG_IRQ, 0, 1, "R7");
        drive(0, 0, 0, 0, 1, 0, 0);
        expect_sig(SIG_EN, 0, 1, "R2");

        // saturation
        for (int k = 0; k < 65540; k++) drive(0, 0, 0, 1, 0, 0, 0);
        expect_sig(SIG_CNT, 65535, 1, "R8");
        drive(0, 0, 0, 1, 0, 0, 0);
        expect_sig(SIG_CNT, 65535, 1, "R8");
        drive(0, 0, 0, 0, 0, 1, 0);
        expect_sig(SIG_CNT, 0, 1, "R9");

        nop();
        nop();
        nop();
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule